// File: doc/BRIEF.md
# UART Buffer Watermark Status

This block sits between a UART's software-visible registers and its bit-level shifters. It keeps one eight-entry first-in-first-out queue for words on their way out and another for words that have come in. From how full each queue is, it derives two status flags. The send flag is raised when the outgoing queue has drained to or below a programmable threshold. The receive flag is raised when the incoming queue has filled to or beyond its own threshold. Software therefore learns that room or data is available in batches, not word by word.

A flag is not dropped just because software touched the data register. Software must first read status while the flag is up; that read arms a clear. The next matching data access (a write for the send side, a read for the receive side) then drops the flag. If the threshold condition still holds after that access, the flag comes back one cycle later. A break-detect mode input keeps the receive flag from rising and makes new incoming words replace the newest stored word. A word that arrives while the receive queue is full is dropped and latched as an overrun. The serializer takes words through a valid/ready pair. The deserializer delivers words through a valid strobe.

Top module: `uart_wm_status`

## Requirements
- R1: Synchronous reset empties both queues, clears both flags and the overrun flag, clears `rdata`, and loads 0 into the send threshold and 1 into the receive threshold. On the first cycle after reset is released, `tx_flag` reads 1 and `rx_flag` reads 0.
- R2: `tx_flag` becomes 1 on the edge after any cycle in which `tx_level` is less than or equal to the send threshold. A word handed to the serializer (`ser_valid` and `ser_ready` both 1) leaves `tx_level` at that edge.
- R3: A `stat_rd` while `tx_flag` is 1, followed later by a `data_wr`, makes `tx_flag` 0 on the edge of that write. It stays 0 while `tx_level` is above the send threshold.
- R4: If `tx_level` is still at or below the send threshold after the clearing write, `tx_flag` reads 0 for exactly one cycle and then 1 again.
- R5: A data access with no armed status read leaves the flag unchanged. A `stat_rd` while the flag is 0 arms nothing. Any matching data access consumes the arm, and the same rules apply to the receive side.
- R6: `rx_flag` becomes 1 on the edge after any cycle in which `rx_level` is greater than or equal to the receive threshold and break mode is off.
- R7: A `stat_rd` while `rx_flag` is 1, followed later by a `data_rd`, makes `rx_flag` 0 on the edge of that read.
- R8: While `brk_mode` is 1, `rx_flag` cannot rise. A word arriving while the receive queue is not empty replaces the most recently stored word, and `rx_level` does not change.
- R9: A word arriving while `rx_level` is 8 (and break mode is not replacing) is dropped, the stored words are kept, and `overrun` becomes 1 and stays 1. It is cleared by a `stat_rd` while it is 1 followed by a `data_rd`. Words keep being accepted while `rx_flag` is 1.
- R10: A `data_wr` while `tx_level` is 8 stores nothing.
- R11: A `data_rd` while the receive queue is empty leaves `rdata` at the last value read and keeps `rx_level` at 0.
- R12: `txwm_wr` or `rxwm_wr` load the 3-bit `wm_wdata` into the send or receive threshold.
- R13: Both queues are first-in-first-out. `rdata` shows the oldest received word on the edge of the `data_rd`, and `ser_data` shows the oldest unsent word whenever `ser_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| wdata | input | DATA_W | Word written to the send queue |
| txwm_wr | input | 1 | Send threshold write strobe |
| rxwm_wr | input | 1 | Receive threshold write strobe |
| wm_wdata | input | WM_W | Threshold value to write |
| brk_mode | input | 1 | Break-detect mode enable |
| des_valid | input | 1 | Deserializer delivers a word |
| des_data | input | DATA_W | Word from the deserializer |
| ser_ready | input | 1 | Serializer takes the offered word |
| ser_valid | output | 1 | Send queue has a word to offer |
| ser_data | output | DATA_W | Oldest unsent word |
| rdata | output | DATA_W | Last word read from the receive queue |
| tx_flag | output | 1 | Send threshold flag |
| rx_flag | output | 1 | Receive threshold flag |
| overrun | output | 1 | Sticky receive overrun flag |
| tx_level | output | $clog2(DEPTH+1) | Words waiting in the send queue |
| rx_level | output | $clog2(DEPTH+1) | Words held in the receive queue |

## Verification
The bench builds the block with its defaults: 8-bit words, 8-entry queues and 3-bit thresholds. At this depth a few random cycles of writes without serializer pull, or arrivals without reads, reach a full queue. That makes the dropped write, the dropped arrival and the overrun latch frequent events and not rare ones. The 3-bit threshold spans every occupancy from 0 to 7, so random threshold writes move both comparisons through every boundary, including a threshold equal to the current level.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;

    typedef enum logic [1:0] {
        RXA_IDLE,
        RXA_PUSH,
        RXA_REPLACE,
        RXA_DROP
    } rx_act_e;

    typedef enum logic {
        CMP_AT_OR_BELOW,
        CMP_AT_OR_ABOVE
    } cmp_mode_e;

    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic data_wr;
    } bus_req_t;

    // Decide what an incoming word does to the receive queue.
    function automatic rx_act_e rx_decide(input logic valid, input logic brk,
                                          input logic empty, input logic full);
        if (!valid)
            return RXA_IDLE;
        else if (brk && !empty)
            return RXA_REPLACE;
        else if (full)
            return RXA_DROP;
        else
            return RXA_PUSH;
    endfunction

endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       replace,
    input  logic                       pop,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              do_push, do_pop, do_repl;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign do_repl = replace && !empty && !do_push;
    assign head    = mem[rd_ptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
        else if (do_repl)
            mem[wr_ptr - PTR_W'(1)] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push)
                wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)
                rd_ptr <= rd_ptr + PTR_W'(1);
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    assert_empty_no_underflow_R11: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (cnt == '0));

endmodule

// File: rtl/uart_wm_flag.sv
module uart_wm_flag
    import uart_wm_pkg::*;
#(
    parameter int        CNT_W = 4,
    parameter int        WM_W  = 3,
    parameter cmp_mode_e MODE  = CMP_AT_OR_BELOW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] level,
    input  logic [WM_W-1:0]  wm,
    input  logic             block,
    input  logic             stat_rd,
    input  logic             data_acc,
    output logic             flag
);
    logic             meets, set_cond, armed;
    logic [CNT_W-1:0] wm_ext;

    assign wm_ext = CNT_W'(wm);

    generate
        if (MODE == CMP_AT_OR_BELOW) begin : g_below
            assign meets = (level <= wm_ext);
        end else begin : g_above
            assign meets = (level >= wm_ext);
        end
    endgenerate

    assign set_cond = meets && !block;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (data_acc)
                armed <= 1'b0;
            else if (stat_rd && flag)
                armed <= 1'b1;

            if (armed && data_acc)
                flag <= 1'b0;
            else if (set_cond)
                flag <= 1'b1;
        end
    end

    // A flag only ever falls on the edge of a data access.
    assert_fall_after_access_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(data_acc));

    // Threshold met with no access pending: flag is up on the next edge.
    assert_set_on_threshold_R2: assert property (@(posedge clk) disable iff (rst)
        (meets && !block && !data_acc) |=> flag);

    // Break mode keeps a low flag low.
    assert_block_keeps_low_R8: assert property (@(posedge clk) disable iff (rst)
        (block && !flag) |=> !flag);

endmodule

// File: rtl/uart_wm_status.sv
module uart_wm_status
    import uart_wm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int WM_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stat_rd,
    input  logic                       data_rd,
    input  logic                       data_wr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       txwm_wr,
    input  logic                       rxwm_wr,
    input  logic [WM_W-1:0]            wm_wdata,
    input  logic                       brk_mode,
    input  logic                       des_valid,
    input  logic [DATA_W-1:0]          des_data,
    input  logic                       ser_ready,
    output logic                       ser_valid,
    output logic [DATA_W-1:0]          ser_data,
    output logic [DATA_W-1:0]          rdata,
    output logic                       tx_flag,
    output logic                       rx_flag,
    output logic                       overrun,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level
);
    localparam int          CNT_W   = $clog2(DEPTH+1);
    localparam logic [WM_W-1:0] TX_WM_RST = WM_W'(0);
    localparam logic [WM_W-1:0] RX_WM_RST = WM_W'(1);

    bus_req_t          req;
    rx_act_e           rx_act;
    logic [WM_W-1:0]   tx_wm, rx_wm;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0] rx_head;
    logic              ov_armed;

    assign req = '{stat_rd: stat_rd, data_rd: data_rd, data_wr: data_wr};

    // Thresholds
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_wm <= TX_WM_RST;
            rx_wm <= RX_WM_RST;
        end else begin
            if (txwm_wr) tx_wm <= wm_wdata;
            if (rxwm_wr) rx_wm <= wm_wdata;
        end
    end

    // Send path
    uart_wm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (req.data_wr),
        .replace (1'b0),
        .pop     (ser_ready),
        .din     (wdata),
        .head    (ser_data),
        .level   (tx_level),
        .empty   (tx_empty),
        .full    (tx_full)
    );

    assign ser_valid = !tx_empty;

    uart_wm_flag #(.CNT_W(CNT_W), .WM_W(WM_W), .MODE(CMP_AT_OR_BELOW)) u_tx_flag (
        .clk      (clk),
        .rst      (rst),
        .level    (tx_level),
        .wm       (tx_wm),
        .block    (1'b0),
        .stat_rd  (req.stat_rd),
        .data_acc (req.data_wr),
        .flag     (tx_flag)
    );

    // Receive path
    assign rx_act = rx_decide(des_valid, brk_mode, rx_empty, rx_full);

    uart_wm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (rx_act == RXA_PUSH),
        .replace (rx_act == RXA_REPLACE),
        .pop     (req.data_rd),
        .din     (des_data),
        .head    (rx_head),
        .level   (rx_level),
        .empty   (rx_empty),
        .full    (rx_full)
    );

    uart_wm_flag #(.CNT_W(CNT_W), .WM_W(WM_W), .MODE(CMP_AT_OR_ABOVE)) u_rx_flag (
        .clk      (clk),
        .rst      (rst),
        .level    (rx_level),
        .wm       (rx_wm),
        .block    (brk_mode),
        .stat_rd  (req.stat_rd),
        .data_acc (req.data_rd),
        .flag     (rx_flag)
    );

    // Read data register and overrun latch
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            overrun  <= 1'b0;
            ov_armed <= 1'b0;
        end else begin
            if (req.data_rd && !rx_empty)
                rdata <= rx_head;

            if (req.data_rd)
                ov_armed <= 1'b0;
            else if (req.stat_rd && overrun)
                ov_armed <= 1'b1;

            if (rx_act == RXA_DROP)
                overrun <= 1'b1;
            else if (ov_armed && req.data_rd)
                overrun <= 1'b0;
        end
    end

    assert_tx_full_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (data_wr && tx_full && !ser_ready) |=> $stable(tx_level));

    assert_empty_read_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (data_rd && rx_empty) |=> $stable(rdata));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overrun && !data_rd) |=> overrun);

    assert_break_no_growth_R8: assert property (@(posedge clk) disable iff (rst)
        (brk_mode && des_valid && !rx_empty && !data_rd) |=> $stable(rx_level));

endmodule

// File: tb/test_uart_wm_status.sv
module test_uart_wm_status;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;
    localparam int WM_W   = 3;
    localparam int CNT_W  = $clog2(DEPTH+1);

    logic              clk = 1'b0;
    logic              rst;
    logic              stat_rd, data_rd, data_wr, txwm_wr, rxwm_wr, brk_mode;
    logic              des_valid, ser_ready;
    logic [DATA_W-1:0] wdata, des_data;
    logic [WM_W-1:0]   wm_wdata;
    logic              ser_valid, tx_flag, rx_flag, overrun;
    logic [DATA_W-1:0] ser_data, rdata;
    logic [CNT_W-1:0]  tx_level, rx_level;

    always #4 clk = ~clk;

    uart_wm_status #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WM_W(WM_W)) i_uart_wm_status (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .wdata(wdata), .txwm_wr(txwm_wr), .rxwm_wr(rxwm_wr), .wm_wdata(wm_wdata),
        .brk_mode(brk_mode), .des_valid(des_valid), .des_data(des_data),
        .ser_ready(ser_ready), .ser_valid(ser_valid), .ser_data(ser_data),
        .rdata(rdata), .tx_flag(tx_flag), .rx_flag(rx_flag), .overrun(overrun),
        .tx_level(tx_level), .rx_level(rx_level)
    );

    int vectors = 0;
    int miscompares = 0;

    // Reference state
    logic [DATA_W-1:0] txq[$];
    logic [DATA_W-1:0] rxq[$];
    bit m_tf, m_ta, m_rf, m_ra, m_ov, m_oa;
    int m_twm, m_rwm;
    logic [DATA_W-1:0] m_rdata;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit next_flag(bit flag, bit armed, bit acc, bit cond);
        if (armed && acc) return 1'b0;
        if (cond) return 1'b1;
        return flag;
    endfunction

    function automatic bit next_arm(bit armed, bit flag, bit acc, bit srd);
        if (acc) return 1'b0;
        if (srd && flag) return 1'b1;
        return armed;
    endfunction

    task automatic model_reset();
        txq.delete(); rxq.delete();
        m_tf = 0; m_ta = 0; m_rf = 0; m_ra = 0; m_ov = 0; m_oa = 0;
        m_twm = 0; m_rwm = 1; m_rdata = '0;
    endtask

    task automatic compare_all();
        chk("R2/R3/R4/R5", "tx_flag", int'(tx_flag), int'(m_tf));
        chk("R6/R7/R8", "rx_flag", int'(rx_flag), int'(m_rf));
        chk("R9", "overrun", int'(overrun), int'(m_ov));
        chk("R10/R2", "tx_level", int'(tx_level), txq.size());
        chk("R8/R9", "rx_level", int'(rx_level), rxq.size());
        chk("R13/R11", "rdata", int'(rdata), int'(m_rdata));
        chk("R13", "ser_valid", int'(ser_valid), int'(txq.size() != 0));
        if (txq.size() != 0)
            chk("R13", "ser_data", int'(ser_data), int'(txq[0]));
    endtask

    // One clock: advance the reference from the present inputs, then compare.
    task automatic step();
        if (rst) begin
            model_reset();
        end else begin
            int  tl = txq.size();
            int  rl = rxq.size();
            bit  tpop = (tl != 0) && ser_ready;
            bit  tpush = data_wr && (tl != DEPTH);
            bit  rpop = data_rd && (rl != 0);
            bit  repl = des_valid && brk_mode && (rl != 0);
            bit  drop = des_valid && !repl && (rl == DEPTH);
            bit  ntf, nta, nrf, nra, nov, noa;
            ntf = next_flag(m_tf, m_ta, data_wr, tl <= m_twm);
            nta = next_arm(m_ta, m_tf, data_wr, stat_rd);
            nrf = next_flag(m_rf, m_ra, data_rd, (rl >= m_rwm) && !brk_mode);
            nra = next_arm(m_ra, m_rf, data_rd, stat_rd);
            nov = drop ? 1'b1 : ((m_oa && data_rd) ? 1'b0 : m_ov);
            noa = next_arm(m_oa, m_ov, data_rd, stat_rd);
            m_tf = ntf; m_ta = nta; m_rf = nrf; m_ra = nra; m_ov = nov; m_oa = noa;
            if (tpop) void'(txq.pop_front());
            if (tpush) txq.push_back(wdata);
            if (rpop) m_rdata = rxq[0];
            if (repl) begin
                if (!(rpop && rl == 1)) rxq[rl-1] = des_data;
            end else if (des_valid && !drop) begin
                rxq.push_back(des_data);
            end
            if (rpop) void'(rxq.pop_front());
            if (txwm_wr) m_twm = int'(wm_wdata);
            if (rxwm_wr) m_rwm = int'(wm_wdata);
        end
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle_inputs();
        stat_rd = 0; data_rd = 0; data_wr = 0; txwm_wr = 0; rxwm_wr = 0;
        des_valid = 0; ser_ready = 0; wdata = '0; des_data = '0; wm_wdata = '0;
    endtask

    task automatic tx_write(input logic [7:0] v);
        data_wr = 1; wdata = v; step(); data_wr = 0;
    endtask
    task automatic status_read();
        stat_rd = 1; step(); stat_rd = 0;
    endtask
    task automatic rx_read();
        data_rd = 1; step(); data_rd = 0;
    endtask
    task automatic rx_arrive(input logic [7:0] v);
        des_valid = 1; des_data = v; step(); des_valid = 0;
    endtask
    task automatic set_txwm(input int v);
        txwm_wr = 1; wm_wdata = WM_W'(v); step(); txwm_wr = 0;
    endtask
    task automatic set_rxwm(input int v);
        rxwm_wr = 1; wm_wdata = WM_W'(v); step(); rxwm_wr = 0;
    endtask

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        idle_inputs();
        brk_mode = 0;
        rst = 1;
        step(); step();
        // R1: reset state
        chk("R1", "tx_level reset", int'(tx_level), 0);
        chk("R1", "overrun reset", int'(overrun), 0);
        chk("R1", "tx_flag in reset", int'(tx_flag), 0);
        rst = 0;
        step();
        chk("R1", "tx_flag after reset", int'(tx_flag), 1);
        chk("R1", "rx_flag after reset", int'(rx_flag), 0);

        // R12, R2, R3: threshold 2, fill to 4 then clear
        set_txwm(2);
        tx_write(8'h11); tx_write(8'h22); tx_write(8'h33);
        chk("R2", "tx_flag sticky above threshold", int'(tx_flag), 1);
        status_read();
        tx_write(8'h44);
        chk("R3", "tx_flag cleared by sequence", int'(tx_flag), 0);
        step();
        chk("R3", "tx_flag stays low above threshold", int'(tx_flag), 0);
        // R5: status read while low arms nothing, write leaves it low
        status_read();
        tx_write(8'h55);
        chk("R5", "tx_flag unchanged", int'(tx_flag), 0);
        // R4: threshold 7, level 5 -> reassert after clear
        set_txwm(7);
        step();
        chk("R12", "tx_flag after raising threshold", int'(tx_flag), 1);
        status_read();
        tx_write(8'h66);
        chk("R4", "tx_flag dips", int'(tx_flag), 0);
        step();
        chk("R4", "tx_flag reasserts", int'(tx_flag), 1);
        // R5: write without armed read leaves flag up
        tx_write(8'h77);
        chk("R5", "tx_flag kept without arm", int'(tx_flag), 1);
        // R10: fill to 8 and write extra
        tx_write(8'h88);
        chk("R10", "tx_level full", int'(tx_level), 8);
        tx_write(8'h99);
        chk("R10", "tx_level after write at full", int'(tx_level), 8);
        // R13: drain in order
        ser_ready = 1;
        for (int i = 0; i < 10; i++) step();
        ser_ready = 0;
        chk("R2", "tx_level drained", int'(tx_level), 0);

        // R6, R7: receive threshold 3
        set_rxwm(3);
        rx_arrive(8'hA1); rx_arrive(8'hA2);
        step();
        chk("R6", "rx_flag below threshold", int'(rx_flag), 0);
        rx_arrive(8'hA3);
        step();
        chk("R6", "rx_flag at threshold", int'(rx_flag), 1);
        rx_read();
        chk("R13", "first word", int'(rdata), 8'hA1);
        chk("R5", "rx_flag kept without arm", int'(rx_flag), 1);
        status_read();
        rx_read();
        chk("R7", "rx_flag cleared", int'(rx_flag), 0);
        rx_read();
        chk("R13", "third word", int'(rdata), 8'hA3);
        // R11: read while empty
        rx_read();
        chk("R11", "rdata holds", int'(rdata), 8'hA3);
        chk("R11", "rx_level stays 0", int'(rx_level), 0);

        // R8: break mode replaces newest word
        set_rxwm(1);
        brk_mode = 1;
        rx_arrive(8'hB1); rx_arrive(8'hB2); rx_arrive(8'hB3);
        step();
        chk("R8", "rx_level in break", int'(rx_level), 1);
        chk("R8", "rx_flag blocked", int'(rx_flag), 0);
        rx_read();
        chk("R8", "newest word kept", int'(rdata), 8'hB3);
        brk_mode = 0;

        // R9: overrun
        for (int i = 0; i < 9; i++) rx_arrive(8'hC0 + 8'(i));
        chk("R9", "overrun set", int'(overrun), 1);
        chk("R9", "rx_level full", int'(rx_level), 8);
        rx_read();
        chk("R9", "stored word kept", int'(rdata), 8'hC0);
        chk("R9", "overrun sticky", int'(overrun), 1);
        status_read();
        rx_read();
        chk("R9", "overrun cleared", int'(overrun), 0);
        for (int i = 0; i < 7; i++) rx_read();
        chk("R9", "ninth word dropped", int'(rdata), 8'hC7);

        // Random phase (all requirements via the reference)
        for (int n = 0; n < 4000; n++) begin
            stat_rd   = ($urandom % 3) == 0;
            data_rd   = ($urandom % 4) == 0;
            data_wr   = ($urandom % 3) == 0;
            des_valid = ($urandom % 3) == 0;
            ser_ready = ($urandom % 4) == 0;
            txwm_wr   = ($urandom % 50) == 0;
            rxwm_wr   = ($urandom % 50) == 0;
            wm_wdata  = WM_W'($urandom);
            wdata     = DATA_W'($urandom);
            des_data  = DATA_W'($urandom);
            if (($urandom % 150) == 0) brk_mode = ~brk_mode;
            step();
        end
        idle_inputs();
        brk_mode = 0;
        step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule